// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block sequences the recording of a probe word into an internal sample store of `DEPTH` entries. A capture is armed with a start pulse. It runs in one of three modes. Single-shot keeps a programmable amount of history from before a trigger event and then records every cycle. Incremental records only the cycles on which the trigger input is high. Immediate records every cycle at once and pays no attention to the trigger. A capture always ends when the store is full. The controller then reports completion and holds its contents until a clear request.

In single-shot mode the store works as a ring. Samples from before the trigger keep overwriting the oldest entry until the trigger is taken. The trigger is taken only once enough history has been written. The number of history samples is programmable. When no value is supplied it defaults to half the depth, which centres the window on the trigger. Values that are too large are limited to `DEPTH-1`.

Readback uses a request stream and a response stream. A request carries a logical index, and index 0 is always the oldest sample retained. A request is accepted on a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` is high only after a capture has completed, and only when the response register is empty or is being emptied in that same cycle. A response stays on `rsp_data` with `rsp_valid` high, unchanged, until `rsp_ready` takes it. Back-pressure on the response side therefore stalls the request side.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset the state is IDLE (code 0), `done` is low and `rd_ready` is low.
- R2: A start pulse is acted on only in IDLE. It latches the mode and the trigger position, then moves to MOVE_TO_POSITION (code 1) for single-shot with a non-zero position, to IN_POSITION (code 2) for single-shot with position 0, or to CAPTURING (code 3) for the other modes. Recording begins on the cycle after the start.
- R3: In single-shot mode the probe is recorded every cycle from the start onward. The trigger is ignored until the number of recorded samples equals the trigger position. After that, the first cycle with `trig` high is recorded as the trigger sample.
- R4: In single-shot mode every cycle after the trigger sample is recorded until the trigger position plus the post-trigger samples, including the trigger sample, total `DEPTH`. The state then becomes CAPTURED (code 4) and `done` goes high.
- R5: Mode code 1 (incremental) records the probe only on cycles where `trig` is high. It completes after `DEPTH` such cycles.
- R6: Mode code 2 (immediate) records every cycle whatever the value of `trig`. It completes after `DEPTH` cycles.
- R7: When `trig_pos_valid` is low the position used is `DEPTH/2`. A programmed position above `DEPTH-1` is limited to `DEPTH-1`.
- R8: Mode code 3 behaves as single-shot, and so does mode code 0.
- R9: After completion, read index i (0 to `DEPTH-1`) returns the i-th oldest of the last `DEPTH` recorded samples.
- R10: `rd_ready` is high only in CAPTURED with the response slot free or draining. A response held while `rsp_ready` is low keeps its data stable.
- R11: `clear` returns the controller to IDLE on the next cycle from any state and takes priority over `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a capture (IDLE only) |
| clear | input | 1 | Return to IDLE |
| mode | input | 2 | 0 single-shot, 1 incremental, 2 immediate, 3 single-shot |
| trig_pos_valid | input | 1 | Use `trig_pos`; otherwise DEPTH/2 |
| trig_pos | input | $clog2(DEPTH)+1 | Requested number of pre-trigger samples |
| trig | input | 1 | Trigger condition |
| probe | input | WIDTH | Probe word sampled each cycle |
| state | output | 3 | Controller state code |
| done | output | 1 | Capture complete |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | $clog2(DEPTH) | Logical read index, 0 = oldest |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | WIDTH | Read response sample |

## Verification
Single-shot runs use several trigger positions: 4 with a trigger placed during positioning, the default centre, a clamped oversize value, and zero. Together these show whether an early trigger is ignored, whether the default and clamp values are used, and whether the ring order is rebuilt correctly on readback. Incremental runs with a periodic trigger and immediate runs with a toggling trigger show whether the trigger gates each write or is ignored. A clear issued together with start, a start issued in CAPTURED, and a response held under back-pressure separate the priority rules and the handshake rules from the capture path.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MOVE  = 3'd1,
    ST_INPOS = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_t;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_INCR   = 2'd1,
    MODE_IMMED  = 2'd2,
    MODE_RSVD   = 2'd3
  } cap_mode_t;
endpackage

// File: rtl/la_pos_select.sv
module la_pos_select #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          pos_valid,
  input  logic [PW-1:0] pos_in,
  output logic [AW-1:0] pos_eff
);
  localparam logic [PW-1:0] POS_MAX = PW'(DEPTH - 1);
  localparam logic [AW-1:0] POS_MID = AW'(DEPTH / 2);

  always_comb begin
    if (!pos_valid)
      pos_eff = POS_MID;
    else if (pos_in > POS_MAX)
      pos_eff = POS_MAX[AW-1:0];
    else
      pos_eff = pos_in[AW-1:0];
  end
endmodule

// File: rtl/la_capture_fsm.sv
module la_capture_fsm
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clear,
  input  logic          trig,
  input  cap_mode_t     mode_in,
  input  logic [AW-1:0] pos_in,
  output cap_state_t    state,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL    = CW'(DEPTH);
  localparam logic [AW-1:0] LASTIDX = AW'(DEPTH - 1);

  cap_mode_t     mode_q;
  logic [AW-1:0] pos_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] limit;

  assign cnt_nx = cnt + CW'(1);
  assign limit  = (mode_q == MODE_SINGLE) ? (FULL - {1'b0, pos_q}) : FULL;

  always_comb begin
    case (state)
      ST_MOVE, ST_INPOS: wr_en = 1'b1;
      ST_CAPT:           wr_en = (mode_q == MODE_INCR) ? trig : 1'b1;
      default:           wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mode_q <= MODE_SINGLE;
      pos_q  <= '0;
      cnt    <= '0;
      wr_ptr <= '0;
    end else if (clear) begin
      state <= ST_IDLE;
    end else begin
      if (wr_en)
        wr_ptr <= (wr_ptr == LASTIDX) ? '0 : wr_ptr + AW'(1);
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= (mode_in == MODE_RSVD) ? MODE_SINGLE : mode_in;
            pos_q  <= pos_in;
            cnt    <= '0;
            wr_ptr <= '0;
            if (mode_in == MODE_INCR || mode_in == MODE_IMMED)
              state <= ST_CAPT;
            else if (pos_in == '0)
              state <= ST_INPOS;
            else
              state <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          cnt <= cnt_nx;
          if (cnt_nx == {1'b0, pos_q})
            state <= ST_INPOS;
        end
        ST_INPOS: begin
          if (trig) begin
            cnt   <= CW'(1);
            state <= (pos_q == LASTIDX) ? ST_DONE : ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (wr_en) begin
            cnt <= cnt_nx;
            if (cnt_nx == limit)
              state <= ST_DONE;
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/la_read_port.sv
module la_read_port #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [AW-1:0]    base,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_ready,
  output logic [AW-1:0]    mem_addr,
  input  logic [WIDTH-1:0] mem_data,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data,
  input  logic             rsp_ready
);
  localparam logic [AW:0] SPAN = (AW+1)'(DEPTH);

  logic [AW:0] sum;

  always_comb begin
    sum = {1'b0, base} + {1'b0, rd_addr};
    if (sum >= SPAN)
      sum = sum - SPAN;
    mem_addr = sum[AW-1:0];
  end

  assign rd_ready = enable && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (clear) begin
      rsp_valid <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic [1:0]       mode,
  input  logic             trig_pos_valid,
  input  logic [PW-1:0]    trig_pos,
  input  logic             trig,
  input  logic [WIDTH-1:0] probe,
  output logic [2:0]       state,
  output logic             done,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [WIDTH-1:0] rsp_data
);
  logic [AW-1:0]    pos_eff;
  cap_state_t       st;
  logic             wr_en;
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    mem_raddr;
  logic [WIDTH-1:0] mem_rdata;

  la_pos_select #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_pos (
    .pos_valid (trig_pos_valid),
    .pos_in    (trig_pos),
    .pos_eff   (pos_eff)
  );

  la_capture_fsm #(.DEPTH(DEPTH), .AW(AW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .clear   (clear),
    .trig    (trig),
    .mode_in (cap_mode_t'(mode)),
    .pos_in  (pos_eff),
    .state   (st),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr)
  );

  la_sample_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr),
    .wr_data (probe),
    .rd_addr (mem_raddr),
    .rd_data (mem_rdata)
  );

  la_read_port #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .enable    (done),
    .base      (wr_ptr),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .mem_addr  (mem_raddr),
    .mem_data  (mem_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ready (rsp_ready)
  );

  assign state = st;
  assign done  = (st == ST_DONE);
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             clear,
  input logic [2:0]       state,
  input logic             done,
  input logic             rd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [WIDTH-1:0] rsp_data
);
  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && !start) |=> state == 3'd0);

  assert_done_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == 3'd2 || $past(state) == 3'd3));

  assert_ready_only_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> done);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !clear) |=> (rsp_valid && $stable(rsp_data)));

  assert_clear_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> state == 3'd0);
endmodule

bind la_capture_ctrl la_capture_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .clear     (clear),
  .state     (state),
  .done      (done),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/la_capture_ctrl_test.sv
module la_capture_ctrl_test;
  localparam int W  = 8;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam int PW = AW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, clear = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          trig_pos_valid = 1'b0;
  logic [PW-1:0] trig_pos = '0;
  logic          trig = 1'b0;
  logic [W-1:0]  probe = '0;
  logic [2:0]    state;
  logic          done;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [AW-1:0] rd_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [W-1:0]  rsp_data;

  int checks = 0, fails = 0, cyc = 0;

  la_capture_ctrl #(.WIDTH(W), .DEPTH(D)) uut (.*);

  always #2 clk = ~clk;

  // behavioural reference model
  int mst = 0, mmode = 0, mpos = 0, mcnt = 0;
  logic [W-1:0] q[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) mst = 0;
    else if (clear) mst = 0;
    else begin
      case (mst)
        0: if (start) begin
          mmode = (mode == 2'd3) ? 0 : int'(mode);
          mpos  = trig_pos_valid ? ((int'(trig_pos) > D-1) ? D-1 : int'(trig_pos)) : D/2;
          q.delete(); mcnt = 0;
          if (mmode != 0) mst = 3; else mst = (mpos == 0) ? 2 : 1;
        end
        1: begin q.push_back(probe); mcnt++; if (mcnt == mpos) mst = 2; end
        2: begin
          q.push_back(probe);
          if (trig) begin mcnt = 1; mst = (mpos == D-1) ? 4 : 3; end
        end
        3: begin
          if (mmode == 0) begin
            q.push_back(probe); mcnt++; if (mcnt == D - mpos) mst = 4;
          end else if (mmode == 2 || trig) begin
            q.push_back(probe); if (q.size() == D) mst = 4;
          end
        end
        default: ;
      endcase
    end
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R2,R3,R4,R5,R6,R11)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(state == 3'(mst), "state model R2 R3 R4 R5 R6 R11", int'(state), mst);
      chk(done == (mst == 4), "done model R4", int'(done), int'(mst == 4));
      if (mst != 4) chk(!rd_ready, "rd_ready outside CAPTURED R10", int'(rd_ready), 0);
    end
  end

  task automatic read_all(input string req);
    for (int i = 0; i < D; i++) begin
      rd_valid = 1'b1; rd_addr = AW'(i);
      @(posedge clk); @(negedge clk);
      rd_valid = 1'b0;
      chk(rsp_valid, {req, " rsp_valid R10"}, int'(rsp_valid), 1);
      chk(rsp_data == q[q.size() - D + i], {req, " order R9"}, int'(rsp_data),
          int'(q[q.size() - D + i]));
    end
    @(negedge clk);
  endtask

  task automatic run(input int md, input bit pv, input int pos,
                     input int ta, input int tb, input int per, input string req);
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    mode = 2'(md); trig_pos_valid = pv; trig_pos = PW'(pos);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int k = 0; k < 300 && mst != 4; k++) begin
      probe = W'(cyc * 37 + 11);
      trig  = (k == ta) || (k == tb) || (per != 0 && (k % per) == 0);
      @(negedge clk);
    end
    trig = 1'b0;
    chk(done, {req, " completes"}, int'(done), 1);
    chk(q.size() >= D, {req, " samples recorded"}, q.size(), D);
    read_all(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(state == 3'd0, "reset state R1", int'(state), 0);
    chk(!done && !rd_ready, "reset done/rd_ready R1", int'(done) + int'(rd_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // single-shot, early trigger during positioning must be ignored (R3)
    run(0, 1, 4, 2, 9, 0, "R3 single pos4");
    run(0, 0, 0, 12, -1, 0, "R7 default pos");
    chk(mpos == D/2, "R7 default position", mpos, D/2);
    run(0, 1, 20, 20, -1, 0, "R7 clamp");
    chk(mpos == D-1, "R7 clamp value", mpos, D-1);
    run(0, 1, 0, 0, -1, 0, "R4 pos zero");
    run(1, 1, 3, -1, -1, 3, "R5 incremental");
    run(2, 1, 3, -1, -1, 2, "R6 immediate");
    run(3, 1, 2, 5, -1, 0, "R8 mode3");
    // start while CAPTURED is ignored (R2)
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(state == 3'd4, "R2 start ignored in CAPTURED", int'(state), 4);
    // back-pressure on the response (R10)
    rsp_ready = 1'b0;
    rd_valid = 1'b1; rd_addr = '0;
    @(posedge clk); @(negedge clk);
    rd_addr = AW'(1);
    chk(!rd_ready, "R10 stall while response held", int'(rd_ready), 0);
    @(posedge clk); @(negedge clk);
    chk(rsp_valid && rsp_data == q[q.size() - D], "R10 response held",
        int'(rsp_data), int'(q[q.size() - D]));
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_data == q[q.size() - D + 1], "R10 next after release R9",
        int'(rsp_data), int'(q[q.size() - D + 1]));
    @(negedge clk);
    // clear together with start mid-capture (R11)
    clear = 1'b1; @(negedge clk); clear = 1'b0;
    mode = 2'd2; start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    clear = 1'b1; start = 1'b1; @(negedge clk); clear = 1'b0; start = 1'b0;
    chk(state == 3'd0, "R11 clear priority", int'(state), 0);
    @(negedge clk);
    chk(state == 3'd0 && !done, "R11 stays idle", int'(state), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule